// File: doc/BRIEF.md
# Processor status word with banked stack pointer

This block keeps the status state of a small 32-bit processor core. It holds three status fields: a six-bit condition field (carry, overflow, zero, negative, interrupt enable and the stack-select flag), a three-bit system control field (trace and two divide-step flags) and an interrupt priority mask. It also holds the architectural stack pointer, which is general register 15, and two saved stack pointer banks, one for system mode and one for user mode. It has four further plain 32-bit dedicated registers: table base, return link, multiply high and multiply low.

Software and the execute stage can reach the status fields in two ways. A 32-bit port covers the whole status word, and one byte port serves each field. The dedicated registers are reached through one port with a 3-bit selector. When an update changes the stack-select flag, the block stores the live stack pointer into the bank being left and loads the live stack pointer from the bank being entered. This all happens in the same clock edge. Reading a bank register that belongs to the active mode returns the live stack pointer, and writing it updates the live stack pointer.

Top module: `psw_stack_bank`

## Requirements
- R1: An asynchronous active-low reset clears the condition and control fields, the stack pointer, both banks and all plain registers to zero, and sets the interrupt mask to 15. The status word then reads 0x000F0000.
- R2: The condition byte maps bit0 to carry, bit1 to overflow, bit2 to zero, bit3 to negative, bit4 to interrupt enable and bit5 to stack select. A write stores bits 5:0 and ignores bits 7:6, which read as zero.
- R3: The control byte maps bit0 to trace, bit1 to divide flag 0 and bit2 to divide flag 1. A write stores bits 2:0, and bits 7:3 read as zero.
- R4: A write to the 5-bit interrupt mask uses bits 4:0 of the written value. If the stored mask is 16 or more and the written value is below 16, the mask becomes the written value plus 16. Otherwise the mask becomes the written value.
- R5: The status word reads as condition bits in 7:0, control bits in 10:8 and mask bits in 20:16, with every other bit zero. A status word write loads all three fields from the same positions, and the R4 rule still applies. In a cycle where the status word port and a byte port both write, the status word port wins.
- R6: When the stack-select flag changes from 0 to 1, the system bank takes the stack pointer value from before the edge, and the stack pointer takes the old user bank value.
- R7: When the stack-select flag changes from 1 to 0, the user bank takes the stack pointer value from before the edge, and the stack pointer takes the old system bank value.
- R8: Writing the stack-select flag with its current value moves nothing between the stack pointer and the banks.
- R9: Dedicated selector code 2 is the system stack pointer and code 3 is the user stack pointer. Code 2 accesses the live stack pointer while the flag is 0, and code 3 accesses it while the flag is 1. In every other case the access reaches the saved bank.
- R10: Selector codes 0 (table base), 1 (return link), 4 (multiply high) and 5 (multiply low) are plain registers that read back what was written. Codes 6 and 7 read zero and ignore writes.
- R11: In a cycle where the stack-select flag changes, direct stack pointer writes and writes to either bank register are dropped.
- R12: The direct stack pointer write port loads the stack pointer on the next edge. It takes priority over a same-cycle write through selector code 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ps_we | input | 1 | Write strobe for the whole status word |
| ps_wdata | input | 32 | Status word write value |
| ps_rdata | output | 32 | Status word read value |
| ccr_we | input | 1 | Condition byte write strobe |
| ccr_wdata | input | 8 | Condition byte write value |
| ccr_rdata | output | 8 | Condition byte read value |
| scr_we | input | 1 | Control byte write strobe |
| scr_wdata | input | 8 | Control byte write value |
| scr_rdata | output | 8 | Control byte read value |
| ilm_we | input | 1 | Interrupt mask byte write strobe |
| ilm_wdata | input | 8 | Interrupt mask write value |
| ilm_rdata | output | 8 | Interrupt mask read value |
| dr_we | input | 1 | Dedicated register write strobe |
| dr_sel | input | 3 | Dedicated register selector |
| dr_wdata | input | 32 | Dedicated register write value |
| dr_rdata | output | 32 | Dedicated register read value, combinational on dr_sel |
| sp_we | input | 1 | Direct stack pointer write strobe |
| sp_wdata | input | 32 | Direct stack pointer write value |
| sp_out | output | 32 | Live stack pointer (general register 15) |

## Verification
The assertions assume that the inputs hold steady across each rising edge and that reset is asserted from time zero. Under those two conditions, every change of the select flag seen at the ports comes from a write on the same edge. The bench drives all strobes one time unit after the rising edge and clears them after one cycle, so every write lasts exactly one edge. The bank-stability property also assumes that no dedicated register write occurred on the previous edge. The bench therefore keeps the dedicated write strobe low on the cycles in which it checks that a same-value flag write moves nothing.

// File: rtl/psw_pkg.sv
package psw_pkg;
   localparam int CCR_W   = 6;
   localparam int SCR_W   = 3;
   localparam int SCR_LSB = 8;
   localparam int ILM_LSB = 16;
   localparam int SEL_BIT = 5;

   typedef enum logic [2:0] {
      DR_TBL    = 3'd0,
      DR_RET    = 3'd1,
      DR_SYS_SP = 3'd2,
      DR_USR_SP = 3'd3,
      DR_MUL_HI = 3'd4,
      DR_MUL_LO = 3'd5,
      DR_NONE6  = 3'd6,
      DR_NONE7  = 3'd7
   } dr_sel_e;
endpackage

// File: rtl/psw_fields.sv
module psw_fields
   import psw_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ILM_W   = 5,
   parameter int ILM_RST = 15
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ps_we,
   input  logic [DATA_W-1:0]       ps_wdata,
   input  logic                    ccr_we,
   input  logic [7:0]              ccr_wdata,
   input  logic                    scr_we,
   input  logic [7:0]              scr_wdata,
   input  logic                    ilm_we,
   input  logic [7:0]              ilm_wdata,
   output logic [CCR_W-1:0]        ccr_q,
   output logic [SCR_W-1:0]        scr_q,
   output logic [ILM_W-1:0]        ilm_q,
   output logic                    sel_q,
   output logic                    sel_d
);
   localparam logic [ILM_W-1:0] ILM_RST_V = ILM_W'(ILM_RST);

   logic [CCR_W-1:0] ccr_d;
   logic [SCR_W-1:0] scr_d;
   logic [ILM_W-1:0] ilm_req;
   logic [ILM_W-1:0] ilm_d;
   logic             ilm_wr;

   // mask may not drop from the upper half into the lower half
   function automatic logic [ILM_W-1:0] clamp_ilm(input logic [ILM_W-1:0] cur,
                                                  input logic [ILM_W-1:0] req);
      logic [ILM_W-1:0] r;
      r = req;
      if (cur[ILM_W-1] && !req[ILM_W-1]) r[ILM_W-1] = 1'b1;
      return r;
   endfunction

   always_comb begin
      ccr_d   = ccr_q;
      scr_d   = scr_q;
      ilm_req = ilm_q;
      ilm_wr  = 1'b0;
      if (ps_we) begin
         ccr_d   = ps_wdata[CCR_W-1:0];
         scr_d   = ps_wdata[SCR_LSB +: SCR_W];
         ilm_req = ps_wdata[ILM_LSB +: ILM_W];
         ilm_wr  = 1'b1;
      end else begin
         if (ccr_we) ccr_d = ccr_wdata[CCR_W-1:0];
         if (scr_we) scr_d = scr_wdata[SCR_W-1:0];
         if (ilm_we) begin
            ilm_req = ilm_wdata[ILM_W-1:0];
            ilm_wr  = 1'b1;
         end
      end
      ilm_d = ilm_wr ? clamp_ilm(ilm_q, ilm_req) : ilm_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ccr_q <= '0;
         scr_q <= '0;
         ilm_q <= ILM_RST_V;
      end else begin
         ccr_q <= ccr_d;
         scr_q <= scr_d;
         ilm_q <= ilm_d;
      end
   end

   assign sel_q = ccr_q[SEL_BIT];
   assign sel_d = ccr_d[SEL_BIT];
endmodule

// File: rtl/sp_bank.sv
module sp_bank #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_q,
   input  logic              sel_d,
   input  logic              sp_we,
   input  logic [DATA_W-1:0] sp_wdata,
   input  logic              sys_we,
   input  logic              usr_we,
   input  logic [DATA_W-1:0] bank_wdata,
   output logic [DATA_W-1:0] sp_q,
   output logic [DATA_W-1:0] sys_q,
   output logic [DATA_W-1:0] usr_q,
   output logic [DATA_W-1:0] sys_view,
   output logic [DATA_W-1:0] usr_view
);
   logic [DATA_W-1:0] sp_d, sys_d, usr_d;
   logic              swap;

   assign swap = sel_q ^ sel_d;

   always_comb begin
      sp_d  = sp_q;
      sys_d = sys_q;
      usr_d = usr_q;
      if (swap) begin
         if (sel_d) begin
            sys_d = sp_q;
            sp_d  = usr_q;
         end else begin
            usr_d = sp_q;
            sp_d  = sys_q;
         end
      end else begin
         if (sys_we) begin
            if (sel_q) sys_d = bank_wdata;
            else       sp_d  = bank_wdata;
         end
         if (usr_we) begin
            if (sel_q) sp_d  = bank_wdata;
            else       usr_d = bank_wdata;
         end
         if (sp_we) sp_d = sp_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q  <= '0;
         sys_q <= '0;
         usr_q <= '0;
      end else begin
         sp_q  <= sp_d;
         sys_q <= sys_d;
         usr_q <= usr_d;
      end
   end

   assign sys_view = sel_q ? sys_q : sp_q;
   assign usr_view = sel_q ? sp_q  : usr_q;
endmodule

// File: rtl/plain_regs.sv
module plain_regs #(
   parameter int DATA_W = 32,
   parameter int NREG   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NREG-1:0]   we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q [NREG]
);
   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     q[i] <= '0;
         else if (we[i]) q[i] <= wdata;
      end
   end
endmodule

// File: rtl/psw_stack_bank.sv
module psw_stack_bank
   import psw_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ILM_W   = 5,
   parameter int ILM_RST = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ps_we,
   input  logic [DATA_W-1:0] ps_wdata,
   output logic [DATA_W-1:0] ps_rdata,
   input  logic              ccr_we,
   input  logic [7:0]        ccr_wdata,
   output logic [7:0]        ccr_rdata,
   input  logic              scr_we,
   input  logic [7:0]        scr_wdata,
   output logic [7:0]        scr_rdata,
   input  logic              ilm_we,
   input  logic [7:0]        ilm_wdata,
   output logic [7:0]        ilm_rdata,
   input  logic              dr_we,
   input  logic [2:0]        dr_sel,
   input  logic [DATA_W-1:0] dr_wdata,
   output logic [DATA_W-1:0] dr_rdata,
   input  logic              sp_we,
   input  logic [DATA_W-1:0] sp_wdata,
   output logic [DATA_W-1:0] sp_out
);
   localparam int NPLAIN = 4;

   if (ILM_W < 2 || ILM_W > 8) begin : g_bad_ilm_w
      $error("ILM_W must lie in 2..8");
   end
   if (ILM_RST < 0 || ILM_RST >= (1 << ILM_W)) begin : g_bad_ilm_rst
      $error("ILM_RST does not fit ILM_W");
   end
   if (DATA_W < ILM_LSB + ILM_W) begin : g_bad_data_w
      $error("DATA_W too narrow for the status word");
   end

   dr_sel_e            sel_e;
   logic [CCR_W-1:0]   ccr_q;
   logic [SCR_W-1:0]   scr_q;
   logic [ILM_W-1:0]   ilm_q;
   logic               sel_q, sel_d;
   logic [DATA_W-1:0]  sp_q, sys_q, usr_q, sys_view, usr_view;
   logic [NPLAIN-1:0]  plain_we;
   logic [DATA_W-1:0]  plain_q [NPLAIN];

   assign sel_e = dr_sel_e'(dr_sel);

   psw_fields #(.DATA_W(DATA_W), .ILM_W(ILM_W), .ILM_RST(ILM_RST)) u_fields (
      .clk(clk), .rst_n(rst_n),
      .ps_we(ps_we), .ps_wdata(ps_wdata),
      .ccr_we(ccr_we), .ccr_wdata(ccr_wdata),
      .scr_we(scr_we), .scr_wdata(scr_wdata),
      .ilm_we(ilm_we), .ilm_wdata(ilm_wdata),
      .ccr_q(ccr_q), .scr_q(scr_q), .ilm_q(ilm_q),
      .sel_q(sel_q), .sel_d(sel_d)
   );

   sp_bank #(.DATA_W(DATA_W)) u_sp (
      .clk(clk), .rst_n(rst_n),
      .sel_q(sel_q), .sel_d(sel_d),
      .sp_we(sp_we), .sp_wdata(sp_wdata),
      .sys_we(dr_we && sel_e == DR_SYS_SP),
      .usr_we(dr_we && sel_e == DR_USR_SP),
      .bank_wdata(dr_wdata),
      .sp_q(sp_q), .sys_q(sys_q), .usr_q(usr_q),
      .sys_view(sys_view), .usr_view(usr_view)
   );

   always_comb begin
      plain_we = '0;
      if (dr_we) begin
         case (sel_e)
            DR_TBL:    plain_we[0] = 1'b1;
            DR_RET:    plain_we[1] = 1'b1;
            DR_MUL_HI: plain_we[2] = 1'b1;
            DR_MUL_LO: plain_we[3] = 1'b1;
            default:   plain_we = '0;
         endcase
      end
   end

   plain_regs #(.DATA_W(DATA_W), .NREG(NPLAIN)) u_plain (
      .clk(clk), .rst_n(rst_n),
      .we(plain_we), .wdata(dr_wdata), .q(plain_q)
   );

   always_comb begin
      case (sel_e)
         DR_TBL:    dr_rdata = plain_q[0];
         DR_RET:    dr_rdata = plain_q[1];
         DR_SYS_SP: dr_rdata = sys_view;
         DR_USR_SP: dr_rdata = usr_view;
         DR_MUL_HI: dr_rdata = plain_q[2];
         DR_MUL_LO: dr_rdata = plain_q[3];
         default:   dr_rdata = '0;
      endcase
   end

   always_comb begin
      ps_rdata = '0;
      ps_rdata[CCR_W-1:0]         = ccr_q;
      ps_rdata[SCR_LSB +: SCR_W]  = scr_q;
      ps_rdata[ILM_LSB +: ILM_W]  = ilm_q;
   end

   assign ccr_rdata = 8'(ccr_q);
   assign scr_rdata = 8'(scr_q);
   assign ilm_rdata = 8'(ilm_q);
   assign sp_out    = sp_q;
endmodule

// File: rtl/psw_stack_bank_chk.sv
module psw_stack_bank_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel,
   input logic [DATA_W-1:0] sp,
   input logic [DATA_W-1:0] sys_bank,
   input logic [DATA_W-1:0] usr_bank,
   input logic              sp_we,
   input logic [DATA_W-1:0] sp_wdata,
   input logic              dr_we,
   input logic              ps_we,
   input logic [DATA_W-1:0] ps_wdata,
   input logic [DATA_W-1:0] ps_rdata,
   input logic [7:0]        ccr_rdata,
   input logic [7:0]        ilm_rdata
);
   p_ccr_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ccr_rdata[7:6] == 2'b00);

   p_ilm_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ilm_rdata[4] |=> ilm_rdata[4]);

   p_word_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ps_we |=> (ps_rdata[5:0] == $past(ps_wdata[5:0]) &&
                 ps_rdata[10:8] == $past(ps_wdata[10:8])));

   p_swap_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel) |-> (sp == $past(usr_bank) && sys_bank == $past(sp)));

   p_swap_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sel) |-> (sp == $past(sys_bank) && usr_bank == $past(sp)));

   p_no_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(sel) && !$past(dr_we)) |-> ($stable(sys_bank) && $stable(usr_bank)));

   p_direct_sp_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sp_we) && $stable(sel)) |-> sp == $past(sp_wdata));
endmodule

bind psw_stack_bank psw_stack_bank_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sel(sel_q), .sp(sp_q),
   .sys_bank(sys_q), .usr_bank(usr_q),
   .sp_we(sp_we), .sp_wdata(sp_wdata), .dr_we(dr_we),
   .ps_we(ps_we), .ps_wdata(ps_wdata), .ps_rdata(ps_rdata),
   .ccr_rdata(ccr_rdata), .ilm_rdata(ilm_rdata)
);

// File: tb/test_psw_stack_bank.sv
module test_psw_stack_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ps_we = 1'b0, ccr_we = 1'b0, scr_we = 1'b0, ilm_we = 1'b0;
   logic        dr_we = 1'b0, sp_we = 1'b0;
   logic [31:0] ps_wdata = '0, dr_wdata = '0, sp_wdata = '0;
   logic [7:0]  ccr_wdata = '0, scr_wdata = '0, ilm_wdata = '0;
   logic [2:0]  dr_sel = '0;
   logic [31:0] ps_rdata, dr_rdata, sp_out;
   logic [7:0]  ccr_rdata, scr_rdata, ilm_rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   psw_stack_bank i_psw_stack_bank (
      .clk(clk), .rst_n(rst_n),
      .ps_we(ps_we), .ps_wdata(ps_wdata), .ps_rdata(ps_rdata),
      .ccr_we(ccr_we), .ccr_wdata(ccr_wdata), .ccr_rdata(ccr_rdata),
      .scr_we(scr_we), .scr_wdata(scr_wdata), .scr_rdata(scr_rdata),
      .ilm_we(ilm_we), .ilm_wdata(ilm_wdata), .ilm_rdata(ilm_rdata),
      .dr_we(dr_we), .dr_sel(dr_sel), .dr_wdata(dr_wdata), .dr_rdata(dr_rdata),
      .sp_we(sp_we), .sp_wdata(sp_wdata), .sp_out(sp_out)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
      ps_we = 0; ccr_we = 0; scr_we = 0; ilm_we = 0; dr_we = 0; sp_we = 0;
   endtask

   task automatic do_reset();
      rst_n = 0;
      step();
      rst_n = 1;
      step();
   endtask

   task automatic set_ccr(input logic [7:0] v);
      ccr_we = 1; ccr_wdata = v; step();
   endtask

   task automatic set_sp(input logic [31:0] v);
      sp_we = 1; sp_wdata = v; step();
   endtask

   task automatic set_dr(input logic [2:0] s, input logic [31:0] v);
      dr_we = 1; dr_sel = s; dr_wdata = v; step();
   endtask

   function automatic logic [31:0] rd_dr(input logic [2:0] s);
      dr_sel = s;
      return 32'(0);
   endfunction

   task automatic read_dr(input logic [2:0] s, output logic [31:0] v);
      dr_sel = s; #1; v = dr_rdata;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      #1;
      step();
      rst_n = 1;
      step();
      // R1: reset state, after dirtying everything
      set_ccr(8'h1F); set_sp(32'h1234); set_dr(3'd0, 32'hAA); set_dr(3'd3, 32'hBB);
      do_reset();
      check("R1 word", ps_rdata, 32'h000F0000);
      check("R1 sp", sp_out, 0);
      for (int s = 0; s < 8; s++) begin
         read_dr(3'(s), v);
         check("R1 dedicated", v, 0);
      end

      // R2: condition byte sweep
      for (int x = 0; x < 256; x++) begin
         set_ccr(8'(x));
         check("R2 ccr", {24'b0, ccr_rdata}, 32'(x & 8'h3F));
      end
      // R3: control byte sweep
      for (int x = 0; x < 256; x++) begin
         scr_we = 1; scr_wdata = 8'(x); step();
         check("R3 scr", {24'b0, scr_rdata}, 32'(x & 7));
         check("R3 word", 32'(ps_rdata[15:8]), 32'(x & 7));
      end

      // R4: mask clamp over every start and request
      for (int c = 0; c < 32; c++) begin
         for (int w = 0; w < 32; w++) begin
            int e;
            do_reset();
            ilm_we = 1; ilm_wdata = 8'(c); step();
            if (w % 2 == 1) begin
               ps_we = 1; ps_wdata = 32'(w) << 16; step();
            end else begin
               ilm_we = 1; ilm_wdata = 8'(w) | 8'hE0; step();
            end
            e = (c >= 16 && w < 16) ? w + 16 : w;
            check("R4 ilm", {24'b0, ilm_rdata}, 32'(e));
            check("R5 ilm in word", 32'(ps_rdata[31:16]), 32'(e));
         end
      end

      // R5: word write layout and priority over byte ports
      do_reset();
      ps_we = 1; ps_wdata = 32'hFFE0_F0DF; ccr_we = 1; ccr_wdata = 8'h01; step();
      check("R5 word", ps_rdata, 32'h0000_001F | 32'h0000_0000 | (32'h0 << 8) | 32'h0);
      ps_we = 1; ps_wdata = 32'h0014_0523; scr_we = 1; scr_wdata = 8'h02; step();
      check("R5 fields", ps_rdata, 32'h0014_0523);
      check("R5 ccr view", {24'b0, ccr_rdata}, 32'h23);

      // R6 / R7 / R8 / R9 / R11 / R12 bank tests
      do_reset();
      set_sp(32'hA000_0001);
      check("R12 direct sp", sp_out, 32'hA000_0001);
      set_dr(3'd3, 32'hB000_0002);                  // user bank saved
      check("R9 sp untouched", sp_out, 32'hA000_0001);
      read_dr(3'd2, v); check("R9 sys live", v, 32'hA000_0001);
      read_dr(3'd3, v); check("R9 usr bank", v, 32'hB000_0002);
      set_ccr(8'h20);
      check("R6 sp from user", sp_out, 32'hB000_0002);
      read_dr(3'd2, v); check("R6 sys saved", v, 32'hA000_0001);
      read_dr(3'd3, v); check("R9 usr live", v, 32'hB000_0002);
      set_sp(32'hC000_0003);
      set_ccr(8'h21);                                // same select value
      check("R8 sp kept", sp_out, 32'hC000_0003);
      read_dr(3'd2, v); check("R8 sys kept", v, 32'hA000_0001);
      set_dr(3'd2, 32'hD000_0004);                   // sys bank while sel=1
      check("R9 sp kept", sp_out, 32'hC000_0003);
      set_dr(3'd3, 32'hE000_0005);                   // live sp while sel=1
      check("R9 usr live write", sp_out, 32'hE000_0005);
      ccr_we = 1; ccr_wdata = 8'h00; sp_we = 1; sp_wdata = 32'hF000_0006; step();
      check("R7 sp from sys", sp_out, 32'hD000_0004);
      read_dr(3'd3, v); check("R7 usr saved pre-edge", v, 32'hE000_0005);
      check("R11 sp write dropped", sp_out, 32'hD000_0004);
      ps_we = 1; ps_wdata = 32'h000F_0020; dr_we = 1; dr_sel = 3'd3; dr_wdata = 32'h1111; step();
      check("R6 word swap sp", sp_out, 32'hE000_0005);
      read_dr(3'd2, v); check("R6 word swap sys", v, 32'hD000_0004);
      read_dr(3'd3, v); check("R11 bank write dropped", v, 32'hE000_0005);
      sp_we = 1; sp_wdata = 32'h2222; dr_we = 1; dr_sel = 3'd3; dr_wdata = 32'h3333; step();
      check("R12 priority", sp_out, 32'h2222);

      // R10 plain registers
      do_reset();
      for (int s = 0; s < 8; s++) begin
         if (s != 2 && s != 3) set_dr(3'(s), 32'h5A00_0000 + 32'(s));
      end
      for (int s = 0; s < 8; s++) begin
         if (s != 2 && s != 3) begin
            read_dr(3'(s), v);
            check("R10 plain", v, (s < 6) ? 32'h5A00_0000 + 32'(s) : 32'h0);
         end
      end
      check("R10 sp untouched", sp_out, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule